// File: doc/BRIEF.md
# Wiper Register Bank Executor

This block runs decoded potentiometer-control instructions against a bank of channels. Each channel owns one volatile wiper register, whose value drives the channel's wiper output, and a small set of stored data registers that model retained settings. An instruction names an operation and a channel and a data-register slot. The operation can read or write a register directly, copy a value between a channel's wiper and one of its data registers, copy across every channel at once, or step a wiper up or down by one.

Instructions arrive on a valid/ready command stream. Read results leave on a valid/ready result stream. The command side stalls while a result is still waiting for the consumer, so the consumer applies back-pressure through `rd_ready`. The command side also stalls during the one-cycle power-up recall and during the timed busy window that follows every store. A store is any operation that changes a data register. An active-low write-protect pin refuses stores. A refused store still completes its handshake and changes nothing.

Top module: `wiper_bank_exec`

## Requirements
- R1: After reset, data register r of channel c holds DR_INIT_BASE + 16*c + 4*r (mod 256). Reset is followed by one recall cycle in which `cmd_ready` is low. From the cycle after that, every wiper equals data register 0 of its own channel (0x40, 0x50, 0x60, 0x70 with defaults), `busy` is low and `rd_valid` is low.
- R2: Opcode 4'b1001 with slot field 00 reads the wiper of channel `cmd_chan`. Opcode 4'b1011 reads data register `cmd_slot` of channel `cmd_chan`. The value appears on `rd_data` with `rd_valid` high in the cycle after acceptance.
- R3: Opcode 4'b1010 with slot field 00 loads `cmd_data` into the wiper of channel `cmd_chan`. The new value shows on `wiper_o[8*c +: 8]` in the cycle after acceptance.
- R4: Opcode 4'b1100 writes `cmd_data` into data register `cmd_slot` of channel `cmd_chan`.
- R5: Opcode 4'b1101 copies data register `cmd_slot` into the wiper of the same channel. Opcode 4'b1110 copies that channel's wiper into its data register `cmd_slot`.
- R6: Opcode 4'b0001 with channel field 00 copies data register `cmd_slot` of every channel into that channel's wiper. Opcode 4'b1000 with channel field 00 copies every wiper into data register `cmd_slot` of its own channel.
- R7: Opcode 4'b0010 with slot field 00 steps the wiper of channel `cmd_chan` by one: up when `cmd_data[0]` is 1, down when it is 0. The wiper saturates at 0xFF and at 0x00.
- R8: An accepted store (opcodes 1100, 1110 and 1000) with `wp_n` high drives `busy` high for exactly STORE_CYCLES cycles, starting the cycle after acceptance. `cmd_ready` is low while `busy` is high.
- R9: While `wp_n` is low, the store opcodes are accepted but change no data register and do not raise `busy`.
- R10: Any other opcode, and any defined opcode whose reserved field is nonzero, is accepted and ignored: no register changes, no result is produced, and `busy` stays low.
- R11: `cmd_ready` is high exactly when the block is not recalling, `busy` is low, and no result is waiting (`rd_valid` low or `rd_ready` high). A waiting result keeps `rd_valid` and `rd_data` stable until `rd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted when high together with cmd_valid |
| cmd_op | input | 4 | Operation code |
| cmd_slot | input | 2 | Data-register slot select |
| cmd_chan | input | 2 | Channel select |
| cmd_data | input | 8 | Write data; bit 0 gives the step direction |
| wp_n | input | 1 | Store protect, active low |
| rd_valid | output | 1 | Read result present |
| rd_ready | input | 1 | Consumer takes the read result |
| rd_data | output | 8 | Read result |
| busy | output | 1 | Store write time in progress |
| wiper_o | output | 32 | Wiper values, channel c at bits 8c+7..8c |

## Verification
A read result leaving on the result stream and the next command entering on the command stream can happen in the same cycle. This happens when `rd_ready` is high while a result waits. The bench provokes it by sending reads back to back while `rd_ready` follows a pseudo-random pattern. The bench's behavioural model handles pop and accept in one step, and the model is compared with `cmd_ready`, `rd_valid`, `rd_data`, `busy` and every wiper on each clock. A lost, duplicated or stale result shows up as a mismatch.

// File: rtl/wbx_pkg.sv
package wbx_pkg;

  typedef enum logic [3:0] {
    OP_GD2W  = 4'b0001,
    OP_STEP  = 4'b0010,
    OP_GW2D  = 4'b1000,
    OP_RD_W  = 4'b1001,
    OP_WR_W  = 4'b1010,
    OP_RD_D  = 4'b1011,
    OP_WR_D  = 4'b1100,
    OP_D2W   = 4'b1101,
    OP_W2D   = 4'b1110
  } op_code_e;

  typedef enum logic [3:0] {
    K_NONE, K_RD_W, K_WR_W, K_RD_D, K_WR_D,
    K_D2W, K_W2D, K_GD2W, K_GW2D, K_STEP
  } kind_e;

  typedef struct packed {
    kind_e kind;
    logic  is_read;
    logic  is_store;
    logic  is_global;
  } dec_t;

endpackage

// File: rtl/wbx_decode.sv
module wbx_decode
  import wbx_pkg::*;
#(
  parameter int CW = 2,
  parameter int RW = 2
) (
  input  logic [3:0]    op,
  input  logic [RW-1:0] slot,
  input  logic [CW-1:0] chan,
  output dec_t          dec
);
  logic slot_zero, chan_zero;

  always_comb begin
    slot_zero = (slot == '0);
    chan_zero = (chan == '0);
    dec = '{kind: K_NONE, is_read: 1'b0, is_store: 1'b0, is_global: 1'b0};
    case (op)
      OP_RD_W: if (slot_zero) dec.kind = K_RD_W;
      OP_WR_W: if (slot_zero) dec.kind = K_WR_W;
      OP_STEP: if (slot_zero) dec.kind = K_STEP;
      OP_RD_D: dec.kind = K_RD_D;
      OP_WR_D: dec.kind = K_WR_D;
      OP_D2W:  dec.kind = K_D2W;
      OP_W2D:  dec.kind = K_W2D;
      OP_GD2W: if (chan_zero) dec.kind = K_GD2W;
      OP_GW2D: if (chan_zero) dec.kind = K_GW2D;
      default: dec.kind = K_NONE;
    endcase
    dec.is_read   = (dec.kind == K_RD_W) || (dec.kind == K_RD_D);
    dec.is_store  = (dec.kind == K_WR_D) || (dec.kind == K_W2D) || (dec.kind == K_GW2D);
    dec.is_global = (dec.kind == K_GD2W) || (dec.kind == K_GW2D);
  end

  always_comb begin
    assert_single_class_R10: assert ($countones({dec.is_read, dec.is_store, dec.kind == K_NONE}) <= 1)
      else $error("decode class overlap");
  end
endmodule

// File: rtl/wbx_store_timer.sv
module wbx_store_timer #(
  parameter int STORE_CYCLES = 500000,
  localparam int TW = $clog2(STORE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic busy
);
  logic [TW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) remain <= '0;
    else if (go) remain <= TW'(STORE_CYCLES);
    else if (remain != '0) remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);

  assert_go_raises_busy_R8: assert property (@(posedge clk) disable iff (rst) go |=> busy)
    else $error("store did not raise busy");
  assert_no_go_when_busy_R8: assert property (@(posedge clk) disable iff (rst) busy |-> !go)
    else $error("store started during busy window");
endmodule

// File: rtl/wbx_channel.sv
module wbx_channel #(
  parameter int W = 8,
  parameter int NREG = 4,
  parameter int CH = 0,
  parameter logic [W-1:0] INIT_BASE = 8'h40,
  localparam int RW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          recall,
  input  logic          wiper_we,
  input  logic [W-1:0]  wiper_wd,
  input  logic          reg_we,
  input  logic [RW-1:0] reg_sel,
  input  logic [W-1:0]  reg_wd,
  output logic [W-1:0]  wiper,
  output logic [W-1:0]  reg_rd
);
  logic [W-1:0] store_q [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    localparam logic [W-1:0] INIT_V = W'(INIT_BASE + W'(CH * 16) + W'(r * 4));
    always_ff @(posedge clk) begin
      if (rst) store_q[r] <= INIT_V;
      else if (reg_we && reg_sel == RW'(r)) store_q[r] <= reg_wd;
    end
  end

  assign reg_rd = store_q[reg_sel];

  always_ff @(posedge clk) begin
    if (rst) wiper <= '0;
    else if (recall) wiper <= store_q[0];
    else if (wiper_we) wiper <= wiper_wd;
  end

  assert_recall_copies_slot0_R1: assert property (@(posedge clk) disable iff (rst)
    recall |=> wiper == $past(store_q[0]))
    else $error("recall mismatch on channel %0d", CH);
  assert_wiper_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!recall && !wiper_we) |=> $stable(wiper))
    else $error("wiper changed without a write on channel %0d", CH);
endmodule

// File: rtl/wiper_bank_exec.sv
module wiper_bank_exec
  import wbx_pkg::*;
#(
  parameter int NCH = 4,
  parameter int W = 8,
  parameter int NREG = 4,
  parameter int STORE_CYCLES = 500000,
  parameter logic [W-1:0] DR_INIT_BASE = 8'h40,
  localparam int CW = $clog2(NCH),
  localparam int RW = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [3:0]       cmd_op,
  input  logic [RW-1:0]    cmd_slot,
  input  logic [CW-1:0]    cmd_chan,
  input  logic [W-1:0]     cmd_data,
  input  logic             wp_n,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [W-1:0]     rd_data,
  output logic             busy,
  output logic [NCH*W-1:0] wiper_o
);
  dec_t         dec;
  logic         accept;
  logic         recall_q;
  logic         store_go;
  logic [W-1:0] wip    [NCH];
  logic [W-1:0] reg_rd [NCH];
  logic [NCH-1:0] wiper_we, reg_we;
  logic [W-1:0] wiper_wd [NCH];
  logic [W-1:0] reg_wd   [NCH];

  wbx_decode #(.CW(CW), .RW(RW)) u_dec (
    .op(cmd_op), .slot(cmd_slot), .chan(cmd_chan), .dec(dec)
  );

  assign cmd_ready = !recall_q && !busy && (!rd_valid || rd_ready);
  assign accept    = cmd_valid && cmd_ready;
  assign store_go  = accept && wp_n && dec.is_store;

  always_ff @(posedge clk) begin
    if (rst) recall_q <= 1'b1;
    else recall_q <= 1'b0;
  end

  wbx_store_timer #(.STORE_CYCLES(STORE_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .go(store_go), .busy(busy)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel;
    logic [W-1:0] stepped;
    assign sel = (cmd_chan == CW'(c));

    always_comb begin
      if (cmd_data[0]) stepped = (wip[c] == '1) ? wip[c] : wip[c] + 1'b1;
      else             stepped = (wip[c] == '0) ? wip[c] : wip[c] - 1'b1;
    end

    always_comb begin
      wiper_we[c] = 1'b0;
      wiper_wd[c] = reg_rd[c];
      if (accept) begin
        case (dec.kind)
          K_WR_W: begin wiper_we[c] = sel; wiper_wd[c] = cmd_data; end
          K_STEP: begin wiper_we[c] = sel; wiper_wd[c] = stepped;  end
          K_D2W:  wiper_we[c] = sel;
          K_GD2W: wiper_we[c] = 1'b1;
          default: wiper_we[c] = 1'b0;
        endcase
      end
    end

    always_comb begin
      reg_we[c] = 1'b0;
      reg_wd[c] = wip[c];
      if (accept && wp_n) begin
        case (dec.kind)
          K_WR_D: begin reg_we[c] = sel; reg_wd[c] = cmd_data; end
          K_W2D:  reg_we[c] = sel;
          K_GW2D: reg_we[c] = 1'b1;
          default: reg_we[c] = 1'b0;
        endcase
      end
    end

    wbx_channel #(.W(W), .NREG(NREG), .CH(c), .INIT_BASE(DR_INIT_BASE)) u_ch (
      .clk(clk), .rst(rst), .recall(recall_q),
      .wiper_we(wiper_we[c]), .wiper_wd(wiper_wd[c]),
      .reg_we(reg_we[c]), .reg_sel(cmd_slot), .reg_wd(reg_wd[c]),
      .wiper(wip[c]), .reg_rd(reg_rd[c])
    );

    assign wiper_o[c*W +: W] = wip[c];

    assert_step_saturates_R7: assert property (@(posedge clk) disable iff (rst)
      (accept && dec.kind == K_STEP && sel && wip[c] == '1 && cmd_data[0]) |=> wip[c] == '1)
      else $error("step wrapped past top on channel %0d", c);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (accept && dec.is_read) begin
      rd_valid <= 1'b1;
      rd_data  <= (dec.kind == K_RD_W) ? wip[cmd_chan] : reg_rd[cmd_chan];
    end else if (rd_ready) begin
      rd_valid <= 1'b0;
    end
  end

  assert_stall_in_busy_R8: assert property (@(posedge clk) disable iff (rst) busy |-> !cmd_ready)
    else $error("command accepted during busy");
  assert_result_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)))
    else $error("waiting result dropped or changed");
  assert_protect_no_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (accept && !wp_n) |=> !busy)
    else $error("refused store raised busy");
  assert_ignored_no_result_R10: assert property (@(posedge clk) disable iff (rst)
    (accept && dec.kind == K_NONE) |=> (!rd_valid && !busy && $stable(wiper_o)))
    else $error("ignored opcode had an effect");
endmodule

// File: tb/wiper_bank_exec_test.sv
`timescale 1ns/100ps
module wiper_bank_exec_test;
  localparam int STORE = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [3:0] cmd_op = '0;
  logic [1:0] cmd_slot = '0, cmd_chan = '0;
  logic [7:0] cmd_data = '0;
  logic wp_n = 1'b1;
  logic rd_valid, busy;
  logic rd_ready = 1'b1;
  logic [7:0] rd_data;
  logic [31:0] wiper_o;

  int checks = 0, errors = 0;
  string phase = "R1";
  bit rnd_mode = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  always #2 clk = ~clk;

  wiper_bank_exec #(.STORE_CYCLES(STORE)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_slot(cmd_slot), .cmd_chan(cmd_chan), .cmd_data(cmd_data),
    .wp_n(wp_n), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .busy(busy), .wiper_o(wiper_o)
  );

  // behavioural reference
  int mdr [4][4];
  int mw [4];
  int mcnt, mrdv, mrdd, mrec;

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 4; c++) begin
        mw[c] = 0;
        for (int r = 0; r < 4; r++) mdr[c][r] = (64 + 16*c + 4*r) % 256;
      end
      mcnt = 0; mrdv = 0; mrdd = 0; mrec = 1;
    end else begin
      bit rdy;
      rdy = (mrec == 0) && (mcnt == 0) && (mrdv == 0 || rd_ready);
      if (mrdv != 0 && rd_ready) mrdv = 0;
      if (mcnt > 0) mcnt--;
      if (mrec != 0) begin
        for (int c = 0; c < 4; c++) mw[c] = mdr[c][0];
        mrec = 0;
      end else if (cmd_valid && rdy) begin
        int c, r, d;
        c = cmd_chan; r = cmd_slot; d = cmd_data;
        case (cmd_op)
          4'b1001: if (r == 0) begin mrdv = 1; mrdd = mw[c]; end
          4'b1011: begin mrdv = 1; mrdd = mdr[c][r]; end
          4'b1010: if (r == 0) mw[c] = d;
          4'b0010: if (r == 0) begin
                     if (d % 2 == 1) mw[c] = (mw[c] < 255) ? mw[c] + 1 : 255;
                     else            mw[c] = (mw[c] > 0) ? mw[c] - 1 : 0;
                   end
          4'b1101: mw[c] = mdr[c][r];
          4'b0001: if (c == 0) for (int k = 0; k < 4; k++) mw[k] = mdr[k][r];
          4'b1100: if (wp_n) begin mdr[c][r] = d; mcnt = STORE; end
          4'b1110: if (wp_n) begin mdr[c][r] = mw[c]; mcnt = STORE; end
          4'b1000: if (wp_n && c == 0) begin
                     for (int k = 0; k < 4; k++) mdr[k][r] = mw[k];
                     mcnt = STORE;
                   end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s got %0h expected %0h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      bit mrdy;
      mrdy = (mrec == 0) && (mcnt == 0) && (mrdv == 0 || rd_ready);
      for (int c = 0; c < 4; c++) chk($sformatf("wiper%0d", c), int'(wiper_o[c*8 +: 8]), mw[c]);
      chk("busy (R8)", int'(busy), int'(mcnt != 0));
      chk("cmd_ready (R11)", int'(cmd_ready), int'(mrdy));
      chk("rd_valid (R2)", int'(rd_valid), mrdv);
      if (mrdv != 0) chk("rd_data (R2)", int'(rd_data), mrdd);
    end
  end

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    #1 rd_ready <= rnd_mode ? lfsr[0] : 1'b1;
  end

  task automatic send(input logic [3:0] op, input logic [1:0] s, input logic [1:0] ch,
                      input logic [7:0] d);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_op = op; cmd_slot = s; cmd_chan = ch; cmd_data = d;
    forever begin
      @(negedge clk);
      if (cmd_ready) break;
    end
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired in %s", phase);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3); #1 rst = 1'b0;
    phase = "R1";
    idle(3);
    phase = "R2";
    send(4'b1001, 2'd0, 2'd2, 8'h00);
    send(4'b1011, 2'd2, 2'd3, 8'h00);
    phase = "R3";
    send(4'b1010, 2'd0, 2'd1, 8'h5A);
    send(4'b1001, 2'd0, 2'd1, 8'h00);
    phase = "R4";
    send(4'b1100, 2'd3, 2'd0, 8'hC3);
    phase = "R8";
    idle(STORE + 2);
    send(4'b1011, 2'd3, 2'd0, 8'h00);
    phase = "R9";
    wp_n = 1'b0;
    send(4'b1100, 2'd1, 2'd1, 8'h11);
    send(4'b1110, 2'd2, 2'd2, 8'h00);
    send(4'b1000, 2'd0, 2'd0, 8'h00);
    send(4'b1011, 2'd1, 2'd1, 8'h00);
    send(4'b1011, 2'd2, 2'd2, 8'h00);
    wp_n = 1'b1;
    phase = "R5";
    send(4'b1101, 2'd3, 2'd0, 8'h00);
    send(4'b1110, 2'd2, 2'd1, 8'h00);
    send(4'b1011, 2'd2, 2'd1, 8'h00);
    phase = "R6";
    send(4'b0001, 2'd2, 2'd0, 8'h00);
    send(4'b1010, 2'd0, 2'd2, 8'h99);
    send(4'b1000, 2'd1, 2'd0, 8'h00);
    for (int c = 0; c < 4; c++) send(4'b1011, 2'd1, 2'(c), 8'h00);
    phase = "R7";
    send(4'b1010, 2'd0, 2'd3, 8'hFE);
    send(4'b0010, 2'd0, 2'd3, 8'h01);
    send(4'b0010, 2'd0, 2'd3, 8'h01);
    send(4'b1010, 2'd0, 2'd3, 8'h01);
    send(4'b0010, 2'd0, 2'd3, 8'h00);
    send(4'b0010, 2'd0, 2'd3, 8'h00);
    phase = "R10";
    send(4'b0000, 2'd0, 2'd0, 8'h77);
    send(4'b1111, 2'd1, 2'd1, 8'h77);
    send(4'b0011, 2'd0, 2'd2, 8'h77);
    send(4'b1010, 2'd1, 2'd0, 8'h77);
    send(4'b0001, 2'd3, 2'd1, 8'h00);
    send(4'b1000, 2'd3, 2'd2, 8'h00);
    send(4'b1011, 2'd3, 2'd2, 8'h00);
    phase = "R11";
    rnd_mode = 1'b1;
    for (int i = 0; i < 24; i++) send((i % 2 == 0) ? 4'b1001 : 4'b1011, 2'(i % 4), 2'(i / 4), 8'h00);
    send(4'b1100, 2'd0, 2'd3, 8'h3C);
    send(4'b1011, 2'd0, 2'd3, 8'h00);
    rnd_mode = 1'b0;
    idle(STORE + 4);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule